// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a UART's serial bit stream and an infrared transceiver. On the send side it takes the NRZ bit stream from a UART transmitter and emits return-to-zero-inverted pulses. A zero bit becomes a short high pulse lasting 3/16 of the bit period. A one bit leaves the infrared line low for the whole period. On the receive side it takes the pulses that the detector reports and rebuilds an NRZ stream for a UART receiver. Each accepted pulse becomes a low bit lasting one full period. With no pulse, the line stays high.

All timing comes from a sample tick at sixteen times the bit rate, which is generated outside the block. The link is half-duplex, so a direction input selects either sending or receiving, and the idle side is held quiet. While sending, the block cannot hear its own echo. An enable input parks both paths. The block targets serial rates of up to 115.2 kbit/s.

The encoder is a state machine with the states TX_IDLE, TX_PULSE and TX_GAP. The transitions are:
- TX_IDLE to TX_PULSE when a tick sees a 0 on the NRZ input.
- TX_PULSE to TX_GAP after three ticks.
- TX_GAP to TX_PULSE at the sixteenth tick of the period if the NRZ input is 0.
- TX_GAP to TX_IDLE at that same tick if the NRZ input is 1.
- Any state to TX_IDLE when the path is inactive.

The decoder has the states RX_IDLE and RX_ZERO. The transitions are:
- RX_IDLE to RX_ZERO on a qualified pulse.
- RX_ZERO to RX_ZERO, with the count restarted, when a qualified pulse arrives in the second half of the period.
- RX_ZERO to RX_IDLE after sixteen ticks.
- Any state to RX_IDLE when the path is inactive.

Top module: `ir_sir_codec`

## Requirements
- R1: The encoder starts a bit period on the first tick that samples `nrz_tx_i` at 0. For a zero bit, `ir_tx_o` goes high after that tick's clock edge. It stays high for exactly 3 ticks and is low for the other 13 ticks of the period.
- R2: A one bit (`nrz_tx_i` = 1) keeps `ir_tx_o` low for the whole 16-tick period.
- R3: The encoder samples the next bit at the 16th tick after a period starts, so consecutive zero bits pulse every 16 ticks. After a one bit, the encoder returns to idle and realigns to the next tick that samples a 0.
- R4: A pulse on `ir_rx_i` is qualified when two consecutive ticks sample it high, after a two-flop synchronizer. `nrz_rx_o` goes low after the second of those ticks and stays low for 16 ticks.
- R5: A pulse that only one tick sample sees high is treated as a glitch and leaves `nrz_rx_o` high.
- R6: A qualified pulse in the second half of a decoded zero restarts the 16-tick low period. Back-to-back zero bits therefore give `nrz_rx_o` a continuous low with no high gap.
- R7: With `dir_tx` = 1, the decoder ignores `ir_rx_i` and `nrz_rx_o` stays high. With `dir_tx` = 0, the encoder is parked and `ir_tx_o` stays low.
- R8: With `enable` = 0, `ir_tx_o` is low and `nrz_rx_o` is high from the next clock edge onward, even in the middle of a pulse or a decoded zero.
- R9: After reset, `ir_tx_o` is low and `nrz_rx_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| enable | input | 1 | 1 = codec active |
| dir_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| nrz_tx_i | input | 1 | NRZ bit stream from the UART transmitter |
| nrz_rx_o | output | 1 | Rebuilt NRZ bit stream to the UART receiver |
| ir_tx_o | output | 1 | Pulse output to the infrared emitter (high = light) |
| ir_rx_i | input | 1 | Pulse input from the infrared detector (high = light) |

## Verification
The hardest case to reach is a run of zero bits on the receive side. There, the pulse for the next bit qualifies on exactly the tick where the previous low period would end, so a restart in the wrong place shows up as a one-tick high gap. The stimulus builds whole frames of pulses placed on the tick grid from a table of bytes, including 0x00 and 0x0F. It then compares `nrz_rx_o` after every tick with the frame delayed by one tick. A single-sample pulse and pulses sent while the direction input selects transmit cover the rejection paths.

// File: rtl/sir_codec_pkg.sv
`timescale 1ns/1ps
package sir_codec_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_ZERO = 1'b1
    } rx_state_t;
endpackage

// File: rtl/sir_sync.sv
`timescale 1ns/1ps
module sir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sir_pulse_encoder.sv
`timescale 1ns/1ps
module sir_pulse_encoder
    import sir_codec_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic nrz_i,
    output logic ir_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_TICKS - 1);
    localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'(OSR - 1);

    tx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!active) begin
            state_d = TX_IDLE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                TX_IDLE: begin
                    if (!nrz_i) begin
                        state_d = TX_PULSE;
                        cnt_d   = '0;
                    end
                end
                TX_PULSE: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == PULSE_LAST) state_d = TX_GAP;
                end
                TX_GAP: begin
                    if (cnt_q == PERIOD_LAST) begin
                        cnt_d   = '0;
                        state_d = nrz_i ? TX_IDLE : TX_PULSE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = TX_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ir_o = (state_q == TX_PULSE);
    end
endmodule

// File: rtl/sir_pulse_decoder.sv
`timescale 1ns/1ps
module sir_pulse_decoder
    import sir_codec_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic ir_s,
    output logic nrz_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HALF        = CNT_W'(OSR / 2);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_q;
    logic             qual;

    // previous tick sample, cleared while inactive so an echo cannot qualify
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (!active) prev_q <= 1'b0;
        else if (tick)   prev_q <= ir_s;
    end

    assign qual = ir_s && prev_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!active) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                RX_IDLE: begin
                    if (qual) begin
                        state_d = RX_ZERO;
                        cnt_d   = '0;
                    end
                end
                RX_ZERO: begin
                    if (qual && (cnt_q >= HALF)) begin
                        cnt_d = '0;
                    end else if (cnt_q == PERIOD_LAST) begin
                        state_d = RX_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = RX_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        nrz_o = (state_q != RX_ZERO);
    end
endmodule

// File: rtl/ir_sir_codec.sv
`timescale 1ns/1ps
module ir_sir_codec #(
    parameter int OSR         = 16,
    parameter int PULSE_TICKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic enable,
    input  logic dir_tx,
    input  logic nrz_tx_i,
    output logic nrz_rx_o,
    output logic ir_tx_o,
    input  logic ir_rx_i
);
    logic tx_active;
    logic rx_active;
    logic ir_rx_s;

    assign tx_active = enable && dir_tx;
    assign rx_active = enable && !dir_tx;

    sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ir_rx_i),
        .q_o   (ir_rx_s)
    );

    sir_pulse_encoder #(.OSR(OSR), .PULSE_TICKS(PULSE_TICKS)) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .active (tx_active),
        .nrz_i  (nrz_tx_i),
        .ir_o   (ir_tx_o)
    );

    sir_pulse_decoder #(.OSR(OSR)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick16),
        .active (rx_active),
        .ir_s   (ir_rx_s),
        .nrz_o  (nrz_rx_o)
    );
endmodule

// File: rtl/ir_sir_codec_sva.sv
`timescale 1ns/1ps
module ir_sir_codec_sva (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic enable,
    input logic dir_tx,
    input logic nrz_tx_i,
    input logic ir_tx_o,
    input logic nrz_rx_o
);
    logic [2:0] hi_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      hi_ticks <= '0;
        else if (!ir_tx_o)               hi_ticks <= '0;
        else if (tick16 && hi_ticks != 3'd7) hi_ticks <= hi_ticks + 3'd1;
    end

    assert_pulse_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx_o) |-> $past(tick16 && !nrz_tx_i && enable && dir_tx));

    assert_pulse_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ir_tx_o |-> (hi_ticks <= 3'd2));

    assert_rx_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nrz_rx_o) |-> $past(tick16));

    assert_echo_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> nrz_rx_o);

    assert_tx_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx |=> !ir_tx_o);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ir_tx_o && nrz_rx_o));
endmodule

bind ir_sir_codec ir_sir_codec_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .enable   (enable),
    .dir_tx   (dir_tx),
    .nrz_tx_i (nrz_tx_i),
    .ir_tx_o  (ir_tx_o),
    .nrz_rx_o (nrz_rx_o)
);

// File: tb/ir_sir_codec_test.sv
`timescale 1ns/1ps
module ir_sir_codec_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic [1:0] tdiv = '0;
    logic enable = 1'b0;
    logic dir_tx = 1'b1;
    logic nrz_tx_i = 1'b1;
    logic ir_rx_i = 1'b0;
    logic nrz_rx_o;
    logic ir_tx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h0F, 8'h81};

    ir_sir_codec uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .enable   (enable),
        .dir_tx   (dir_tx),
        .nrz_tx_i (nrz_tx_i),
        .nrz_rx_o (nrz_rx_o),
        .ir_tx_o  (ir_tx_o),
        .ir_rx_i  (ir_rx_i)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd2);
    end

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // advance past one consumed tick, landing on a falling clock edge
    task automatic tick_step();
        do @(negedge clk); while (!tick16);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_step();
    endtask

    // frame bits: index 0 = start, 1..8 = data LSB first, 9 = stop
    task automatic run_tx_frame(input logic [9:0] bits, input string req, input bit expect_pulses);
        int bad;
        logic act_f;
        logic exp_f;
        bad = 0; act_f = 1'b0; exp_f = 1'b0;
        for (int k = 0; k < 12; k++) begin
            logic b;
            b = (k < 10) ? bits[k] : 1'b1;
            nrz_tx_i = b;
            for (int p = 0; p < 16; p++) begin
                logic e;
                tick_step();
                e = expect_pulses && !b && (p < 3);
                if (ir_tx_o !== e) begin
                    if (bad == 0) begin act_f = ir_tx_o; exp_f = e; end
                    bad++;
                end
            end
        end
        nrz_tx_i = 1'b1;
        chk(bad == 0, req, act_f, exp_f);
    endtask

    task automatic run_rx_frame(input logic [9:0] bits, input string req, input bit expect_decode);
        int bad;
        logic act_f;
        logic exp_f;
        bad = 0; act_f = 1'b0; exp_f = 1'b0;
        for (int m = 0; m < 184; m++) begin
            int k;
            int p;
            int idx;
            logic e;
            k = m / 16;
            p = m % 16;
            ir_rx_i = (k < 10) && !bits[k] && (p < 3);
            tick_step();
            idx = (m - 1) / 16;
            e = (expect_decode && m >= 1 && idx < 10) ? bits[idx] : 1'b1;
            if (nrz_rx_o !== e) begin
                if (bad == 0) begin act_f = nrz_rx_o; exp_f = e; end
                bad++;
            end
        end
        ir_rx_i = 1'b0;
        chk(bad == 0, req, act_f, exp_f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] fr;
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(ir_tx_o === 1'b0, "R9 ir_tx after reset", ir_tx_o, 1'b0);
        chk(nrz_rx_o === 1'b1, "R9 nrz_rx after reset", nrz_rx_o, 1'b1);
        rst_n = 1'b1;
        enable = 1'b1;
        ticks(4);

        // table-driven frames through both paths (R1 R2 R3, R4 R6)
        for (int v = 0; v < NVEC; v++) begin
            fr = {1'b1, VEC[v], 1'b0};
            dir_tx = 1'b1;
            ticks(2);
            run_tx_frame(fr, $sformatf("R1/R2/R3 tx frame %02h", VEC[v]), 1'b1);
            dir_tx = 1'b0;
            ticks(4);
            run_rx_frame(fr, $sformatf("R4/R6 rx frame %02h", VEC[v]), 1'b1);
        end

        // R3 realign after idle of unaligned length
        dir_tx = 1'b1;
        ticks(2);
        nrz_tx_i = 1'b0;
        ticks(16);
        nrz_tx_i = 1'b1;
        ticks(23);
        chk(ir_tx_o === 1'b0, "R2 idle ones stay low", ir_tx_o, 1'b0);
        nrz_tx_i = 1'b0;
        tick_step();
        chk(ir_tx_o === 1'b1, "R3 realigned pulse tick0", ir_tx_o, 1'b1);
        ticks(2);
        chk(ir_tx_o === 1'b1, "R3 realigned pulse tick2", ir_tx_o, 1'b1);
        tick_step();
        chk(ir_tx_o === 1'b0, "R1 pulse ends after 3 ticks", ir_tx_o, 1'b0);
        nrz_tx_i = 1'b1;
        ticks(20);

        // R8 disable mid pulse on transmit
        nrz_tx_i = 1'b0;
        tick_step();
        enable = 1'b0;
        @(negedge clk);
        chk(ir_tx_o === 1'b0, "R8 disable cuts tx pulse", ir_tx_o, 1'b0);
        ticks(20);
        chk(ir_tx_o === 1'b0, "R8 disabled tx stays low", ir_tx_o, 1'b0);
        enable = 1'b1;
        nrz_tx_i = 1'b1;
        ticks(20);

        // R7 tx direction: pulses on ir_rx ignored, encoder still works
        dir_tx = 1'b1;
        run_rx_frame(10'b1_0000_0000_0, "R7 echo ignored in tx direction", 1'b0);
        // R7 rx direction: encoder parked
        dir_tx = 1'b0;
        run_tx_frame(10'b1_0000_0000_0, "R7 tx parked in rx direction", 1'b0);
        ticks(4);

        // R5 single-sample glitch rejected
        ir_rx_i = 1'b1;
        tick_step();
        ir_rx_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick_step();
            if (nrz_rx_o !== 1'b1) begin
                chk(1'b0, "R5 glitch rejected", nrz_rx_o, 1'b1);
                break;
            end
        end
        chk(nrz_rx_o === 1'b1, "R5 glitch rejected end", nrz_rx_o, 1'b1);

        // R4 two-sample pulse accepted, 16-tick low
        ir_rx_i = 1'b1;
        tick_step();
        chk(nrz_rx_o === 1'b1, "R4 first sample not yet", nrz_rx_o, 1'b1);
        tick_step();
        ir_rx_i = 1'b0;
        chk(nrz_rx_o === 1'b0, "R4 low after second sample", nrz_rx_o, 1'b0);
        ticks(15);
        chk(nrz_rx_o === 1'b0, "R4 low through 16th tick", nrz_rx_o, 1'b0);
        tick_step();
        chk(nrz_rx_o === 1'b1, "R4 high after 16 ticks", nrz_rx_o, 1'b1);
        ticks(4);

        // R8 disable mid decoded zero, and pulses ignored while disabled
        ir_rx_i = 1'b1;
        ticks(2);
        ir_rx_i = 1'b0;
        chk(nrz_rx_o === 1'b0, "R8 decoded zero before disable", nrz_rx_o, 1'b0);
        enable = 1'b0;
        @(negedge clk);
        chk(nrz_rx_o === 1'b1, "R8 disable releases nrz_rx", nrz_rx_o, 1'b1);
        run_rx_frame(10'b1_0000_0000_0, "R8 disabled rx stays high", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule